// File: doc/BRIEF.md
# Disk Controller Programmed-I/O Register Front End

This block sits between a 12-bit processor's I/O bus and the internals of a cartridge disk controller. Each bus cycle with `iot_valid` high carries a 3-bit pulse code and the 12-bit accumulator. The block decodes that pair. It keeps the command word, the disk address, the memory address and the status word. It answers with a skip flag and a returned accumulator value, and it raises one interrupt request.

The block does not move data and does not time seeks. When software starts a function, the block emits a single-cycle `go` strobe carrying the function code, the target cylinder and the selected drive. A separate sequencer picks it up. That sequencer and the transfer engine report back through a status-set vector and a pair of busy set and clear lines. Each drive also supplies a not-ready flag and a heads-moving flag. While the controller is busy, every register load is refused and flagged as a busy error. One clear pulse selects among four housekeeping actions with the two low accumulator bits.

Top module: `dkc_iot_frontend`

## Requirements
- R1: A synchronous reset clears the command, disk address, memory address and status registers, the busy flag, the interrupt request and the go and cancel strobes.
- R2: Pulse code 1 returns the accumulator unchanged, and it asserts skip in the same cycle when status has done (octal 4000) or any error bit set. The error bits are octal 0100, 0040, 0020, 0010, 0004, 0002 and 0001. No other pulse ever asserts skip.
- R3: The interrupt request is high exactly when the status holds done or an error bit, and command bit 8 (octal 0400) is set. It follows every register update one cycle after the edge.
- R4: When the controller is idle, pulse code 6 loads the command register from the accumulator and clears status.
- R5: When the controller is idle, pulse code 4 loads the memory address register from the accumulator.
- R6: When the controller is idle, pulse code 3 loads the disk address from the accumulator and raises `go` for one cycle. The strobe carries function = command bits [11:9], cylinder = {command bit 0, accumulator bits [11:5]} and drive = command bits [2:1].
- R7: While busy, pulse codes 3, 4 and 6 change no register and raise no `go`; instead they set the busy-error status bit (octal 0100).
- R8: Pulse code 2 clears status and then acts on accumulator bits [1:0]. With 0, it sets busy error if busy. With 3, it does nothing more. With 1, it clears command, disk address, memory address and busy, and pulses `cancel_all`. With 2, it sets busy error if busy; otherwise it issues `go` with function 3 (seek) and cylinder 0.
- R9: Pulse code 5 replaces status bit octal 2000 with the selected drive's heads-moving flag and bit octal 0200 with its not-ready flag. It returns that refreshed status on the accumulator and keeps it in the register.
- R10: Pulse codes 0, 2, 3, 4, 6 and 7 return an accumulator of zero. Codes 0 and 7 change no state.
- R11: Event bits on `ev_set` (mask octal 6777) are set in status at the next edge, even when a pulse in the same cycle clears status. `ev_busy_set` wins over a clear of the busy flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iot_valid | input | 1 | An I/O pulse is present this cycle |
| iot_code | input | 3 | Pulse code |
| ac_in | input | 12 | Accumulator from the processor |
| drv_not_ready | input | NDRV | Per-drive not-ready flag |
| drv_moving | input | NDRV | Per-drive heads-moving flag |
| ev_set | input | 12 | Status bits to set, from sequencer and transfer engine |
| ev_busy_set | input | 1 | Mark controller busy |
| ev_busy_clr | input | 1 | Mark controller idle |
| ac_out | output | 12 | Accumulator value returned to the processor |
| skip | output | 1 | Skip request for the current pulse |
| irq | output | 1 | Interrupt request |
| go | output | 1 | Single-cycle start strobe to the sequencer |
| go_func | output | 3 | Function code carried with go |
| go_cyl | output | 8 | Target cylinder carried with go |
| go_drive | output | 2 | Selected drive carried with go |
| cancel_all | output | 1 | Single-cycle request to stop all drive activity |
| cmd_word | output | 12 | Command register contents |
| disk_addr | output | 12 | Disk address register contents |
| mem_addr | output | 12 | Memory address register contents |

## Verification
The bench builds the block with its default of four drives. With that value, every code of the two-bit drive-select field reaches a real drive, so the status read on code 5 exercises the drive multiplexer over its full range. The random stream asserts and drops the busy flag and injects events in the same cycles as clear pulses. This covers the refusal paths and the set-over-clear priority as well as the idle loads.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  localparam int WORD_W = 12;
  localparam int CYL_W  = 8;

  localparam logic [WORD_W-1:0] ST_DONE    = 12'o4000;
  localparam logic [WORD_W-1:0] ST_HMOV    = 12'o2000;
  localparam logic [WORD_W-1:0] ST_NRDY    = 12'o0200;
  localparam logic [WORD_W-1:0] ST_BUSYERR = 12'o0100;
  localparam logic [WORD_W-1:0] ST_ERRS    = 12'o0177;
  localparam logic [WORD_W-1:0] ST_EVMASK  = 12'o6777;
  localparam int CMD_IE_BIT = 8;
  localparam logic [2:0] FN_SEEK = 3'd3;

  typedef enum logic [2:0] {
    P_NONE = 3'd0, P_POLL = 3'd1, P_CLEAR = 3'd2, P_ADDRGO = 3'd3,
    P_MEMADR = 3'd4, P_STATRD = 3'd5, P_CMDLD = 3'd6, P_NOP = 3'd7
  } pulse_e;

  typedef enum logic [1:0] {
    CL_STAT = 2'd0, CL_CTRL = 2'd1, CL_DRIVE = 2'd2, CL_STALT = 2'd3
  } clr_e;

  typedef struct packed {
    logic ld_cmd;
    logic ld_da;
    logic ld_ma;
    logic clr_sta;
    logic clr_ctl;
    logic seek0;
    logic start;
    logic busy_err;
    logic refresh;
  } act_t;

  function automatic logic [CYL_W-1:0] fn_cyl(input logic [WORD_W-1:0] cmd,
                                               input logic [WORD_W-1:0] da);
    return {cmd[0], da[11:5]};
  endfunction

  function automatic logic [1:0] fn_drv(input logic [WORD_W-1:0] cmd);
    return cmd[2:1];
  endfunction

  function automatic logic fn_attn(input logic [WORD_W-1:0] sta);
    return |(sta & (ST_DONE | ST_ERRS));
  endfunction

  function automatic logic [WORD_W-1:0] fn_refresh(input logic [WORD_W-1:0] sta,
                                                   input logic mov,
                                                   input logic nrdy);
    return (sta & ~(ST_HMOV | ST_NRDY)) | (mov ? ST_HMOV : '0) | (nrdy ? ST_NRDY : '0);
  endfunction
endpackage

// File: rtl/dkc_pulse_decode.sv
module dkc_pulse_decode
  import dkc_pkg::*;
(
  input  logic       iot_valid,
  input  logic [2:0] iot_code,
  input  logic [1:0] clr_sel,
  input  logic       busy,
  output act_t       act
);
  always_comb begin
    act = '0;
    if (iot_valid) begin
      unique case (pulse_e'(iot_code))
        P_CLEAR: begin
          act.clr_sta = 1'b1;
          unique case (clr_e'(clr_sel))
            CL_STAT:  act.busy_err = busy;
            CL_CTRL:  act.clr_ctl  = 1'b1;
            CL_DRIVE: begin
              act.busy_err = busy;
              act.seek0    = !busy;
            end
            default: ;
          endcase
        end
        P_ADDRGO: begin
          act.busy_err = busy;
          act.ld_da    = !busy;
          act.start    = !busy;
        end
        P_MEMADR: begin
          act.busy_err = busy;
          act.ld_ma    = !busy;
        end
        P_CMDLD: begin
          act.busy_err = busy;
          act.ld_cmd   = !busy;
          act.clr_sta  = !busy;
        end
        P_STATRD: act.refresh = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dkc_drive_sel.sv
module dkc_drive_sel #(
  parameter int NDRV = 4
) (
  input  logic [NDRV-1:0] drv_not_ready,
  input  logic [NDRV-1:0] drv_moving,
  input  logic [1:0]      sel,
  output logic            sel_nrdy,
  output logic            sel_mov
);
  localparam int SLOTS = 4;
  logic [SLOTS-1:0] nrdy_pad;
  logic [SLOTS-1:0] mov_pad;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NDRV) begin : g_real
      assign nrdy_pad[i] = drv_not_ready[i];
      assign mov_pad[i]  = drv_moving[i];
    end else begin : g_absent
      assign nrdy_pad[i] = 1'b1;
      assign mov_pad[i]  = 1'b0;
    end
  end

  assign sel_nrdy = nrdy_pad[sel];
  assign sel_mov  = mov_pad[sel];
endmodule

// File: rtl/dkc_status_reg.sv
module dkc_status_reg
  import dkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  act_t              act,
  input  logic              sel_mov,
  input  logic              sel_nrdy,
  input  logic [WORD_W-1:0] ev_set,
  output logic [WORD_W-1:0] sta_q,
  output logic [WORD_W-1:0] sta_d,
  output logic [WORD_W-1:0] sta_view
);
  logic [WORD_W-1:0] base;
  logic [WORD_W-1:0] ev_bits;

  assign sta_view = fn_refresh(sta_q, sel_mov, sel_nrdy);
  assign ev_bits  = ev_set & ST_EVMASK;

  always_comb begin
    if (act.clr_sta)      base = '0;
    else if (act.refresh) base = sta_view;
    else                  base = sta_q;
    sta_d = base | (act.busy_err ? ST_BUSYERR : '0) | ev_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) sta_q <= '0;
    else     sta_q <= sta_d;
  end

  // R11: an event bit is present after the edge, whatever the pulse did
  a_r11_event_sets: assert property (@(posedge clk) disable iff (rst)
    (|ev_bits) |=> ((sta_q & $past(ev_bits)) == $past(ev_bits)));

  // R9: a status read stores the selected drive's heads-moving flag
  a_r9_refresh_mov: assert property (@(posedge clk) disable iff (rst)
    (act.refresh && !ev_set[10]) |=> (sta_q[10] == $past(sel_mov)));
endmodule

// File: rtl/dkc_ctl_regs.sv
module dkc_ctl_regs
  import dkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  act_t              act,
  input  logic [WORD_W-1:0] ac_in,
  input  logic              ev_busy_set,
  input  logic              ev_busy_clr,
  output logic [WORD_W-1:0] cmd_q,
  output logic [WORD_W-1:0] cmd_d,
  output logic [WORD_W-1:0] da_q,
  output logic [WORD_W-1:0] ma_q,
  output logic              busy_q,
  output logic              go_q,
  output logic [2:0]        go_func_q,
  output logic [CYL_W-1:0]  go_cyl_q,
  output logic [1:0]        go_drive_q,
  output logic              cancel_q
);
  logic issue;

  assign issue = act.start | act.seek0;

  always_comb begin
    if (act.clr_ctl)     cmd_d = '0;
    else if (act.ld_cmd) cmd_d = ac_in;
    else                 cmd_d = cmd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= '0;
      da_q       <= '0;
      ma_q       <= '0;
      busy_q     <= 1'b0;
      go_q       <= 1'b0;
      go_func_q  <= '0;
      go_cyl_q   <= '0;
      go_drive_q <= '0;
      cancel_q   <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      if (act.clr_ctl)    da_q <= '0;
      else if (act.ld_da) da_q <= ac_in;
      if (act.clr_ctl)    ma_q <= '0;
      else if (act.ld_ma) ma_q <= ac_in;
      if (ev_busy_set)                     busy_q <= 1'b1;
      else if (act.clr_ctl || ev_busy_clr) busy_q <= 1'b0;
      go_q     <= issue;
      cancel_q <= act.clr_ctl;
      if (issue) begin
        go_drive_q <= fn_drv(cmd_q);
        go_func_q  <= act.start ? cmd_q[11:9] : FN_SEEK;
        go_cyl_q   <= act.start ? fn_cyl(cmd_q, ac_in) : '0;
      end
    end
  end

  // R4: an accepted command load shows the accumulator on the next cycle
  a_r4_cmd_load: assert property (@(posedge clk) disable iff (rst)
    act.ld_cmd |=> (cmd_q == $past(ac_in)));

  // R7: a refused load leaves all three registers untouched
  a_r7_regs_hold: assert property (@(posedge clk) disable iff (rst)
    (act.busy_err && !act.clr_sta) |=> ($stable(cmd_q) && $stable(da_q) && $stable(ma_q)));

  // R8: the cancel strobe comes with cleared registers
  a_r8_cancel_clears: assert property (@(posedge clk) disable iff (rst)
    cancel_q |-> (cmd_q == '0 && da_q == '0 && ma_q == '0));
endmodule

// File: rtl/dkc_iot_frontend.sv
module dkc_iot_frontend
  import dkc_pkg::*;
#(
  parameter int NDRV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iot_valid,
  input  logic [2:0]        iot_code,
  input  logic [WORD_W-1:0] ac_in,
  input  logic [NDRV-1:0]   drv_not_ready,
  input  logic [NDRV-1:0]   drv_moving,
  input  logic [WORD_W-1:0] ev_set,
  input  logic              ev_busy_set,
  input  logic              ev_busy_clr,
  output logic [WORD_W-1:0] ac_out,
  output logic              skip,
  output logic              irq,
  output logic              go,
  output logic [2:0]        go_func,
  output logic [CYL_W-1:0]  go_cyl,
  output logic [1:0]        go_drive,
  output logic              cancel_all,
  output logic [WORD_W-1:0] cmd_word,
  output logic [WORD_W-1:0] disk_addr,
  output logic [WORD_W-1:0] mem_addr
);
  act_t              act;
  logic              busy_q;
  logic [WORD_W-1:0] cmd_q, cmd_d, da_q, ma_q;
  logic [WORD_W-1:0] sta_q, sta_d, sta_view;
  logic              sel_nrdy, sel_mov;
  logic              irq_q;

  dkc_pulse_decode u_dec (
    .iot_valid (iot_valid),
    .iot_code  (iot_code),
    .clr_sel   (ac_in[1:0]),
    .busy      (busy_q),
    .act       (act)
  );

  dkc_drive_sel #(.NDRV(NDRV)) u_dsel (
    .drv_not_ready (drv_not_ready),
    .drv_moving    (drv_moving),
    .sel           (fn_drv(cmd_q)),
    .sel_nrdy      (sel_nrdy),
    .sel_mov       (sel_mov)
  );

  dkc_status_reg u_sta (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .sel_mov  (sel_mov),
    .sel_nrdy (sel_nrdy),
    .ev_set   (ev_set),
    .sta_q    (sta_q),
    .sta_d    (sta_d),
    .sta_view (sta_view)
  );

  dkc_ctl_regs u_ctl (
    .clk         (clk),
    .rst         (rst),
    .act         (act),
    .ac_in       (ac_in),
    .ev_busy_set (ev_busy_set),
    .ev_busy_clr (ev_busy_clr),
    .cmd_q       (cmd_q),
    .cmd_d       (cmd_d),
    .da_q        (da_q),
    .ma_q        (ma_q),
    .busy_q      (busy_q),
    .go_q        (go),
    .go_func_q   (go_func),
    .go_cyl_q    (go_cyl),
    .go_drive_q  (go_drive),
    .cancel_q    (cancel_all)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= fn_attn(sta_d) & cmd_d[CMD_IE_BIT];
  end

  always_comb begin
    ac_out = '0;
    skip   = 1'b0;
    if (iot_valid) begin
      unique case (pulse_e'(iot_code))
        P_POLL: begin
          ac_out = ac_in;
          skip   = fn_attn(sta_q);
        end
        P_STATRD: ac_out = sta_view;
        default: ;
      endcase
    end
  end

  assign irq       = irq_q;
  assign cmd_word  = cmd_q;
  assign disk_addr = da_q;
  assign mem_addr  = ma_q;

  // R3: the request tracks the stored status and enable bit
  a_r3_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (fn_attn(sta_q) && cmd_q[CMD_IE_BIT]));

  // R2: skip only ever answers the poll pulse
  a_r2_skip_only_poll: assert property (@(posedge clk) disable iff (rst)
    skip |-> (iot_valid && iot_code == 3'd1));

  // R7: nothing is started while the controller is busy
  a_r7_no_go_busy: assert property (@(posedge clk) disable iff (rst)
    (iot_valid && busy_q) |=> !go);
endmodule

// File: tb/dkc_iot_frontend_bench.sv
module dkc_iot_frontend_bench;
  localparam int NDRV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iot_valid = 1'b0;
  logic [2:0]  iot_code = '0;
  logic [11:0] ac_in = '0;
  logic [NDRV-1:0] drv_not_ready = '0;
  logic [NDRV-1:0] drv_moving = '0;
  logic [11:0] ev_set = '0;
  logic        ev_busy_set = 1'b0;
  logic        ev_busy_clr = 1'b0;
  logic [11:0] ac_out;
  logic        skip, irq, go, cancel_all;
  logic [2:0]  go_func;
  logic [7:0]  go_cyl;
  logic [1:0]  go_drive;
  logic [11:0] cmd_word, disk_addr, mem_addr;

  always #5 clk = ~clk;

  dkc_iot_frontend #(.NDRV(NDRV)) u_dkc_iot_frontend (
    .clk(clk), .rst(rst), .iot_valid(iot_valid), .iot_code(iot_code),
    .ac_in(ac_in), .drv_not_ready(drv_not_ready), .drv_moving(drv_moving),
    .ev_set(ev_set), .ev_busy_set(ev_busy_set), .ev_busy_clr(ev_busy_clr),
    .ac_out(ac_out), .skip(skip), .irq(irq), .go(go), .go_func(go_func),
    .go_cyl(go_cyl), .go_drive(go_drive), .cancel_all(cancel_all),
    .cmd_word(cmd_word), .disk_addr(disk_addr), .mem_addr(mem_addr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [11:0] m_cmd, m_da, m_ma, m_sta;
  bit m_busy;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit f_attention(input logic [11:0] s);
    return (s & 12'o4177) != 12'o0;
  endfunction

  function automatic logic [7:0] f_cylinder(input logic [11:0] c, input logic [11:0] a);
    return 8'((c & 12'd1) << 7) | 8'(a >> 5);
  endfunction

  function automatic bit f_refused(input bit v, input logic [2:0] c, input logic [11:0] a, input bit b);
    if (!v || !b) return 0;
    return (c == 3) || (c == 4) || (c == 6) || (c == 2 && (a[1:0] == 0 || a[1:0] == 2));
  endfunction

  task automatic step(input bit v, input logic [2:0] c, input logic [11:0] a,
                      input logic [11:0] evs, input bit bs, input bit bc);
    logic [1:0]  sel;
    logic [11:0] view, nsta, ncmd, nda, nma, eac;
    bit eskip, ego, ectl, eclr, erefuse, nbusy;
    logic [2:0] efunc;
    logic [7:0] ecyl;
    @(negedge clk);
    iot_valid = v; iot_code = c; ac_in = a;
    ev_set = evs; ev_busy_set = bs; ev_busy_clr = bc;
    #1;
    sel  = m_cmd[2:1];
    view = (m_sta & ~12'o2200) | (drv_moving[sel] ? 12'o2000 : 12'o0)
                               | (drv_not_ready[sel] ? 12'o0200 : 12'o0);
    eskip = v && c == 1 && f_attention(m_sta);
    eac   = !v ? 12'o0 : (c == 1) ? a : (c == 5) ? view : 12'o0;
    chk("R2 skip", skip, eskip);
    if (v && c == 5) chk("R9 status read", ac_out, eac);
    else if (v && c == 1) chk("R2 ac kept", ac_out, eac);
    else chk("R10 ac zero", ac_out, eac);
    erefuse = f_refused(v, c, a, m_busy);
    ectl = v && c == 2 && a[1:0] == 1;
    eclr = v && (c == 2 || (c == 6 && !m_busy));
    nsta = eclr ? 12'o0 : (v && c == 5) ? view : m_sta;
    nsta = nsta | (erefuse ? 12'o0100 : 12'o0) | (evs & 12'o6777);
    ncmd = ectl ? 12'o0 : (v && c == 6 && !m_busy) ? a : m_cmd;
    nda  = ectl ? 12'o0 : (v && c == 3 && !m_busy) ? a : m_da;
    nma  = ectl ? 12'o0 : (v && c == 4 && !m_busy) ? a : m_ma;
    ego  = v && !m_busy && (c == 3 || (c == 2 && a[1:0] == 2));
    efunc = (c == 3) ? m_cmd[11:9] : 3'd3;
    ecyl  = (c == 3) ? f_cylinder(m_cmd, a) : 8'd0;
    nbusy = bs ? 1'b1 : (ectl || bc) ? 1'b0 : m_busy;
    @(posedge clk);
    #1;
    chk("R6 go strobe", go, ego);
    if (ego) begin
      chk("R6 go func", go_func, efunc);
      chk("R6 go cyl", go_cyl, ecyl);
      chk("R6 go drive", go_drive, sel);
    end
    chk("R8 cancel", cancel_all, ectl);
    chk("R4 cmd", cmd_word, ncmd);
    chk("R6 disk addr", disk_addr, nda);
    chk("R5 mem addr", mem_addr, nma);
    chk("R3 irq", irq, f_attention(nsta) && ncmd[8]);
    m_cmd = ncmd; m_da = nda; m_ma = nma; m_sta = nsta; m_busy = nbusy;
  endtask

  task automatic read_status(input string tag, input logic [11:0] exp);
    step(1, 3'd5, 12'o0, 12'o0, 0, 0);
    chk(tag, m_sta, exp);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    m_cmd = 0; m_da = 0; m_ma = 0; m_sta = 0; m_busy = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 cmd reset", cmd_word, 12'o0);
    chk("R1 da reset", disk_addr, 12'o0);
    chk("R1 ma reset", mem_addr, 12'o0);
    chk("R1 irq reset", irq, 1'b0);
    chk("R1 go reset", go, 1'b0);
    @(negedge clk);
    rst = 0;
    read_status("R1 status reset", 12'o0);

    // R4 R6: load command with IE, drive 2, cyl high bit, function 4
    step(1, 3'd6, 12'o4505, 12'o0, 0, 0);
    step(1, 3'd3, 12'o7760, 12'o0, 0, 0);
    // R11: done event then poll skip and irq
    step(0, 3'd0, 12'o0, 12'o4000, 0, 0);
    step(1, 3'd1, 12'o1234, 12'o0, 0, 0);
    // R7: busy refusals
    step(0, 3'd0, 12'o0, 12'o0, 1, 0);
    step(1, 3'd4, 12'o0777, 12'o0, 0, 0);
    step(1, 3'd3, 12'o0777, 12'o0, 0, 0);
    read_status("R7 busy error bit", 12'o4100);
    // R8: seek refused while busy, then clear control with busy set winning
    step(1, 3'd2, 12'o0002, 12'o0, 0, 0);
    step(1, 3'd2, 12'o0001, 12'o0, 1, 0);
    step(1, 3'd6, 12'o0400, 12'o0, 0, 0);
    step(0, 3'd0, 12'o0, 12'o0, 0, 1);
    // R8: seek to zero when idle; R11 set beats clear
    step(1, 3'd2, 12'o0002, 12'o0, 0, 0);
    step(1, 3'd2, 12'o0003, 12'o0001, 0, 0);
    read_status("R11 set over clear", 12'o0001);
    // R9: refresh on each drive
    for (int d = 0; d < NDRV; d++) begin
      step(1, 3'd6, 12'(d << 1), 12'o0, 0, 0);
      drv_moving = NDRV'(1 << d);
      drv_not_ready = ~NDRV'(1 << d);
      read_status("R9 drive flags", 12'o2000);
    end
    // R10: codes 0 and 7 leave state alone
    step(1, 3'd7, 12'o7777, 12'o0, 0, 0);
    step(1, 3'd0, 12'o7777, 12'o0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [11:0] evs;
      drv_moving = NDRV'($urandom);
      drv_not_ready = NDRV'($urandom);
      evs = ($urandom % 8 == 0) ? 12'($urandom) : 12'o0;
      step($urandom % 5 != 0, 3'($urandom), 12'($urandom), evs,
           $urandom % 12 == 0, $urandom % 6 == 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule